// File: doc/BRIEF.md
# Timer Tick and Interrupt Arbiter

This block pairs an 8-bit up-counting timer with the interrupt acceptance logic of a small 4-bit controller core. The core writes the timer as a whole byte or as single nibbles, and reads both nibbles on two ports. It starts and stops the timer with one-cycle strobes. While the timer runs, it advances once every 2^TICK_EXP system clocks. When the timer wraps from its top value to zero, a timer flag is raised. The flag is also the timer's interrupt request.

The arbiter tracks the interrupt-enable state, which is set and cleared by strobes. It watches the core's call-active and halt status, and it samples seven input pins for falling edges, each pin gated by its own wake enable. When a request is accepted, the block issues a one-cycle vector request carrying address 4 (timer) or 8 (pin). It also signals a wake-up when it brings the core out of halt. If interrupts are disabled, that wake-up carries no vector, and the core resumes after its halt instruction.

Top module: `tiu_top`

## Requirements
- R1: After reset the count reads 00h and the timer is stopped. The flag, the interrupt enable, the vector request and the wake-up output are all 0.
- R2: A whole-byte load sets the count in the next cycle. A low-nibble load writes only bits 3:0, and a high-nibble load writes only bits 7:4. A load takes precedence over counting.
- R3: While running, the count rises by exactly one every 2^TICK_EXP cycles. The first step comes 2^TICK_EXP cycles after the cycle in which the start strobe takes effect. After a stop strobe the count holds.
- R4: A step from FFh reads 00h, and the timer flag reads 1 in that same cycle. Counting then continues from 00h.
- R5: The timer flag is cleared by the test strobe and by acceptance of the timer interrupt.
- R6: The enable strobe sets the interrupt enable and the disable strobe clears it. When both arrive in the same cycle, disable wins.
- R7: A pending timer flag with interrupts enabled and no call active produces, in the next cycle, a one-cycle vector request with address 4 (vecAddr = 4'h4). While the enable is clear or a call is active, the request is held.
- R8: A pin raises the external request only on a high-to-low transition, only while its wake-enable bit is 1, and only while the core is halted. Rising edges and edges outside halt have no effect.
- R9: When the external request is accepted, the block outputs a vector request with address 8 (vecAddr = 4'h8) four cycles after the pin change. If the core is halted, wakeUp is 1 in that same cycle. The request is then cleared.
- R10: If a pin edge is latched during halt while interrupts are disabled, the block pulses wakeUp without a vector request and discards the request.
- R11: When both requests are pending, the timer is vectored first. Further pin edges that arrive while the external request is already latched merge into that single request.
- R12: No request is accepted in the cycle that directly follows a vector request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdLoadAll | input | 1 | Load loadByte into the count |
| loadByte | input | 8 | Whole-byte load value |
| cmdLoadLo | input | 1 | Write nibbleIn into the low nibble |
| cmdLoadHi | input | 1 | Write nibbleIn into the high nibble |
| nibbleIn | input | 4 | Nibble load value |
| cmdStart | input | 1 | Start counting, restarting the prescaler |
| cmdStop | input | 1 | Stop counting (wins over start) |
| cmdTestFlag | input | 1 | Test-and-clear of the timer flag |
| cmdEnable | input | 1 | Enable interrupts |
| cmdDisable | input | 1 | Disable interrupts |
| callActive | input | 1 | Core is inside a called routine |
| inHalt | input | 1 | Core is halted |
| pins | input | 7 | Asynchronous input pins |
| pinWakeEn | input | 7 | Per-pin edge enable |
| countLo | output | 4 | Count bits 3:0 |
| countHi | output | 4 | Count bits 7:4 |
| timerFlag | output | 1 | Timer overflow flag |
| intEnabled | output | 1 | Interrupt enable state |
| vecReq | output | 1 | One-cycle vector request |
| vecAddr | output | 4 | Vector address, valid with vecReq |
| wakeUp | output | 1 | One-cycle wake-from-halt indication |

## Verification
Loads and strobe effects show one cycle after the strobe. A count step shows exactly 2^TICK_EXP cycles after the start takes effect, and the flag rises in the same cycle as the wrap to 00h. A timer vector follows the enabling condition by one cycle, and a pin vector or wake-up lands four cycles after the pin falls (two synchronizer stages, the latch, then the output register). The bench drives every input at the falling clock edge and advances a known number of rising edges before it samples. Each check therefore reads the cycle in which the result is due. For the ignore and hold cases, the bench samples every cycle over a window and counts any pulse on vecReq or wakeUp.

// File: rtl/tiu_pkg.sv
package tiu_pkg;
  typedef struct packed {
    logic loadAll;
    logic loadLo;
    logic loadHi;
    logic countEn;
  } tmrStrobe_t;

  localparam int VEC_W = 4;
  localparam logic [VEC_W-1:0] VEC_TIMER = 4'h4;
  localparam logic [VEC_W-1:0] VEC_EXT   = 4'h8;
endpackage

// File: rtl/tiu_datapath.sv
module tiu_datapath
  import tiu_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strb,
  input  logic [2*NIB_W-1:0] loadByte,
  input  logic [NIB_W-1:0]   nibbleIn,
  output logic [2*NIB_W-1:0] count,
  output logic               ovf
);
  localparam int CNT_W = 2 * NIB_W;

  logic [CNT_W-1:0] cntQ;
  logic anyLoad;

  assign anyLoad = strb.loadAll | strb.loadLo | strb.loadHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.loadAll) begin
      cntQ <= loadByte;
    end else if (strb.loadLo || strb.loadHi) begin
      if (strb.loadLo) cntQ[NIB_W-1:0] <= nibbleIn;
      if (strb.loadHi) cntQ[CNT_W-1:NIB_W] <= nibbleIn;
    end else if (strb.countEn) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  // Wrap from all-ones to zero on a counting edge, not masked by a load.
  assign ovf   = strb.countEn & (&cntQ) & ~anyLoad;
  assign count = cntQ;
endmodule

// File: rtl/tiu_control.sv
module tiu_control
  import tiu_pkg::*;
#(
  parameter int PIN_W    = 7,
  parameter int TICK_EXP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdLoadAll,
  input  logic             cmdLoadLo,
  input  logic             cmdLoadHi,
  input  logic             cmdStart,
  input  logic             cmdStop,
  input  logic             cmdTestFlag,
  input  logic             cmdEnable,
  input  logic             cmdDisable,
  input  logic             callActive,
  input  logic             inHalt,
  input  logic [PIN_W-1:0] pins,
  input  logic [PIN_W-1:0] pinWakeEn,
  input  logic             ovf,
  output tmrStrobe_t       strb,
  output logic             timerFlag,
  output logic             intEnabled,
  output logic             vecReq,
  output logic [VEC_W-1:0] vecAddr,
  output logic             wakeUp
);
  localparam int PRE_W = (TICK_EXP > 0) ? TICK_EXP : 1;

  // Run state and prescaler
  logic runQ;
  logic [PRE_W-1:0] preQ;
  logic tickEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0;
      preQ <= '0;
    end else begin
      if (cmdStop)       runQ <= 1'b0;
      else if (cmdStart) runQ <= 1'b1;
      if (cmdStart)      preQ <= '0;
      else if (runQ)     preQ <= preQ + 1'b1;
    end
  end

  generate
    if (TICK_EXP == 0) begin : g_noDiv
      assign tickEn = runQ;
    end else begin : g_div
      assign tickEn = runQ & (&preQ);
    end
  endgenerate

  always_comb begin
    strb.loadAll = cmdLoadAll;
    strb.loadLo  = cmdLoadLo;
    strb.loadHi  = cmdLoadHi;
    strb.countEn = tickEn;
  end

  // Pin synchronizers and falling-edge detect, idle high after reset
  logic [PIN_W-1:0] fallVec;

  generate
    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      logic s1Q, s2Q, s3Q;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          s1Q <= 1'b1;
          s2Q <= 1'b1;
          s3Q <= 1'b1;
        end else begin
          s1Q <= pins[i];
          s2Q <= s1Q;
          s3Q <= s2Q;
        end
      end
      assign fallVec[i] = s3Q & ~s2Q & pinWakeEn[i];
    end
  endgenerate

  // Arbitration
  logic tfQ, ieQ, extQ, vecReqQ, wakeQ;
  logic [VEC_W-1:0] vecAddrQ;
  logic canTake, takeTmr, takeExt, wakeNoVec;

  assign canTake   = ieQ & ~callActive & ~vecReqQ;
  assign takeTmr   = canTake & tfQ;
  assign takeExt   = canTake & extQ & ~tfQ;
  assign wakeNoVec = inHalt & extQ & ~ieQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tfQ      <= 1'b0;
      ieQ      <= 1'b0;
      extQ     <= 1'b0;
      vecReqQ  <= 1'b0;
      vecAddrQ <= '0;
      wakeQ    <= 1'b0;
    end else begin
      if (ovf)                          tfQ <= 1'b1;
      else if (cmdTestFlag || takeTmr)  tfQ <= 1'b0;

      if (cmdDisable)     ieQ <= 1'b0;
      else if (cmdEnable) ieQ <= 1'b1;

      // New edges merge into a latched request; a set beats a clear
      if (inHalt && (|fallVec))          extQ <= 1'b1;
      else if (takeExt || wakeNoVec)     extQ <= 1'b0;

      vecReqQ <= takeTmr | takeExt;
      if (takeTmr)      vecAddrQ <= VEC_TIMER;
      else if (takeExt) vecAddrQ <= VEC_EXT;
      wakeQ <= inHalt & (takeExt | wakeNoVec);
    end
  end

  assign timerFlag  = tfQ;
  assign intEnabled = ieQ;
  assign vecReq     = vecReqQ;
  assign vecAddr    = vecAddrQ;
  assign wakeUp     = wakeQ;
endmodule

// File: rtl/tiu_top.sv
module tiu_top
  import tiu_pkg::*;
#(
  parameter int PIN_W    = 7,
  parameter int NIB_W    = 4,
  parameter int TICK_EXP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdLoadAll,
  input  logic [2*NIB_W-1:0] loadByte,
  input  logic               cmdLoadLo,
  input  logic               cmdLoadHi,
  input  logic [NIB_W-1:0]   nibbleIn,
  input  logic               cmdStart,
  input  logic               cmdStop,
  input  logic               cmdTestFlag,
  input  logic               cmdEnable,
  input  logic               cmdDisable,
  input  logic               callActive,
  input  logic               inHalt,
  input  logic [PIN_W-1:0]   pins,
  input  logic [PIN_W-1:0]   pinWakeEn,
  output logic [NIB_W-1:0]   countLo,
  output logic [NIB_W-1:0]   countHi,
  output logic               timerFlag,
  output logic               intEnabled,
  output logic               vecReq,
  output logic [VEC_W-1:0]   vecAddr,
  output logic               wakeUp
);
  tmrStrobe_t strb;
  logic ovf;
  logic [2*NIB_W-1:0] count;

  tiu_control #(.PIN_W(PIN_W), .TICK_EXP(TICK_EXP)) u_ctl (
    .clk(clk), .rstN(rstN),
    .cmdLoadAll(cmdLoadAll), .cmdLoadLo(cmdLoadLo), .cmdLoadHi(cmdLoadHi),
    .cmdStart(cmdStart), .cmdStop(cmdStop), .cmdTestFlag(cmdTestFlag),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable),
    .callActive(callActive), .inHalt(inHalt),
    .pins(pins), .pinWakeEn(pinWakeEn), .ovf(ovf),
    .strb(strb), .timerFlag(timerFlag), .intEnabled(intEnabled),
    .vecReq(vecReq), .vecAddr(vecAddr), .wakeUp(wakeUp)
  );

  tiu_datapath #(.NIB_W(NIB_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .loadByte(loadByte), .nibbleIn(nibbleIn),
    .count(count), .ovf(ovf)
  );

  assign countLo = count[NIB_W-1:0];
  assign countHi = count[2*NIB_W-1:NIB_W];
endmodule

// File: rtl/tiu_checker.sv
module tiu_checker
  import tiu_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdLoadAll,
  input logic             cmdLoadLo,
  input logic             cmdLoadHi,
  input logic             cmdDisable,
  input logic             callActive,
  input logic             inHalt,
  input logic [NIB_W-1:0] countLo,
  input logic [NIB_W-1:0] countHi,
  input logic             timerFlag,
  input logic             intEnabled,
  input logic             vecReq,
  input logic [VEC_W-1:0] vecAddr,
  input logic             wakeUp
);
  localparam int CNT_W = 2 * NIB_W;
  logic [CNT_W-1:0] cnt;
  logic anyLoad;
  assign cnt     = {countHi, countLo};
  assign anyLoad = cmdLoadAll | cmdLoadLo | cmdLoadHi;

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(anyLoad) && cnt != $past(cnt)) |-> cnt == CNT_W'($past(cnt) + 1'b1));

  a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(anyLoad) && $past(cnt) == {CNT_W{1'b1}} && cnt == '0) |-> timerFlag);

  a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    cmdDisable |=> !intEnabled);

  a_r7_vec_legal_addr: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |-> (vecAddr == VEC_TIMER || vecAddr == VEC_EXT));

  a_r7_vec_needs_ie: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |-> ($past(intEnabled) && !$past(callActive)));

  a_r9_wake_from_halt: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp |-> $past(inHalt));

  a_r10_bare_wake_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (wakeUp && !vecReq) |-> !$past(intEnabled));

  a_r12_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |=> !vecReq);
endmodule

bind tiu_top tiu_checker #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdLoadAll(cmdLoadAll), .cmdLoadLo(cmdLoadLo),
  .cmdLoadHi(cmdLoadHi), .cmdDisable(cmdDisable), .callActive(callActive),
  .inHalt(inHalt), .countLo(countLo), .countHi(countHi),
  .timerFlag(timerFlag), .intEnabled(intEnabled), .vecReq(vecReq),
  .vecAddr(vecAddr), .wakeUp(wakeUp)
);

// File: tb/test_tiu_top.sv
module test_tiu_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdLoadAll = 0, cmdLoadLo = 0, cmdLoadHi = 0;
  logic [7:0] loadByte = '0;
  logic [3:0] nibbleIn = '0;
  logic cmdStart = 0, cmdStop = 0, cmdTestFlag = 0;
  logic cmdEnable = 0, cmdDisable = 0, callActive = 0, inHalt = 0;
  logic [6:0] pins = '1, pinWakeEn = '1;
  logic [3:0] countLo, countHi, vecAddr;
  logic timerFlag, intEnabled, vecReq, wakeUp;

  int nRun = 0, nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiu_top #(.TICK_EXP(TICK)) i_tiu_top (
    .clk(clk), .rstN(rstN), .cmdLoadAll(cmdLoadAll), .loadByte(loadByte),
    .cmdLoadLo(cmdLoadLo), .cmdLoadHi(cmdLoadHi), .nibbleIn(nibbleIn),
    .cmdStart(cmdStart), .cmdStop(cmdStop), .cmdTestFlag(cmdTestFlag),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .callActive(callActive),
    .inHalt(inHalt), .pins(pins), .pinWakeEn(pinWakeEn),
    .countLo(countLo), .countHi(countHi), .timerFlag(timerFlag),
    .intEnabled(intEnabled), .vecReq(vecReq), .vecAddr(vecAddr), .wakeUp(wakeUp)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic quietFor(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (vecReq || wakeUp) hits++;
    end
  endtask

  task automatic doReset();
    rstN = 0; callActive = 0; inHalt = 0; pins = '1; pinWakeEn = '1;
    step(3);
    rstN = 1;
    step(1);
  endtask

  task automatic loadFull(input logic [7:0] v);
    cmdLoadAll = 1; loadByte = v; step(1); cmdLoadAll = 0;
  endtask
  task automatic startTimer(); cmdStart = 1; step(1); cmdStart = 0; endtask
  task automatic stopTimer();  cmdStop = 1;  step(1); cmdStop = 0;  endtask
  task automatic enableInt();  cmdEnable = 1; step(1); cmdEnable = 0; endtask

  task automatic tReset();
    int hits;
    doReset();
    chk("R1 count", {countHi, countLo}, 8'h00);
    chk("R1 flag", timerFlag, 0);
    chk("R1 enable", intEnabled, 0);
    chk("R1 vec/wake", {vecReq, wakeUp}, 0);
    quietFor(10, hits);
    chk("R1 stopped count", {countHi, countLo}, 8'h00);
  endtask

  task automatic tLoads();
    doReset();
    loadFull(8'hA5);
    chk("R2 byte load", {countHi, countLo}, 8'hA5);
    cmdLoadLo = 1; nibbleIn = 4'h3; step(1); cmdLoadLo = 0;
    chk("R2 low nibble", {countHi, countLo}, 8'hA3);
    cmdLoadHi = 1; nibbleIn = 4'hC; step(1); cmdLoadHi = 0;
    chk("R2 high nibble", {countHi, countLo}, 8'hC3);
  endtask

  task automatic tCount();
    doReset();
    loadFull(8'h10);
    startTimer();
    step(3);
    chk("R3 before first step", {countHi, countLo}, 8'h10);
    step(1);
    chk("R3 first step", {countHi, countLo}, 8'h11);
    step(4);
    chk("R3 second step", {countHi, countLo}, 8'h12);
    stopTimer();
    step(20);
    chk("R3 stopped holds", {countHi, countLo}, 8'h12);
    // a load while running takes precedence over the step
    startTimer(); step(2);
    loadFull(8'h40);
    chk("R2 load while running", {countHi, countLo}, 8'h40);
    stopTimer();
  endtask

  task automatic tWrap();
    doReset();
    loadFull(8'hFE);
    startTimer();
    step(4);
    chk("R4 at FF", {countHi, countLo}, 8'hFF);
    step(3);
    chk("R4 flag before wrap", timerFlag, 0);
    step(1);
    chk("R4 wrapped count", {countHi, countLo}, 8'h00);
    chk("R4 flag on wrap", timerFlag, 1);
    step(4);
    chk("R4 keeps counting", {countHi, countLo}, 8'h01);
    cmdTestFlag = 1; step(1); cmdTestFlag = 0;
    chk("R5 test clears flag", timerFlag, 0);
    stopTimer();
  endtask

  task automatic tEnable();
    doReset();
    enableInt();
    chk("R6 enable", intEnabled, 1);
    cmdDisable = 1; step(1); cmdDisable = 0;
    chk("R6 disable", intEnabled, 0);
    cmdEnable = 1; cmdDisable = 1; step(1); cmdEnable = 0; cmdDisable = 0;
    chk("R6 disable wins", intEnabled, 0);
  endtask

  task automatic tTimerVec();
    int hits;
    doReset();
    loadFull(8'hFF);
    startTimer();
    step(4);
    chk("R4 flag set", timerFlag, 1);
    stopTimer();
    quietFor(5, hits);
    chk("R7 held while disabled", hits, 0);
    callActive = 1;
    enableInt();
    quietFor(4, hits);
    chk("R7 held while call active", hits, 0);
    callActive = 0;
    step(1);
    chk("R7 timer vector", vecReq, 1);
    chk("R7 timer address", vecAddr, 4'h4);
    chk("R5 acceptance clears flag", timerFlag, 0);
    callActive = 1;
    step(1);
    chk("R7 one-cycle request", vecReq, 0);
    callActive = 0;
  endtask

  task automatic tExtVec();
    doReset();
    enableInt();
    inHalt = 1;
    pins[3] = 0;
    step(3);
    chk("R9 not yet due", {vecReq, wakeUp}, 0);
    step(1);
    chk("R9 ext vector", vecReq, 1);
    chk("R9 ext address", vecAddr, 4'h8);
    chk("R9 wake", wakeUp, 1);
    callActive = 1; inHalt = 0;
    step(1);
    chk("R9 pulse ends", {vecReq, wakeUp}, 0);
    pins = '1; callActive = 0;
  endtask

  task automatic tIgnored();
    int hits;
    doReset();
    enableInt();
    pins[0] = 0;
    quietFor(8, hits);
    chk("R8 edge outside halt", hits, 0);
    inHalt = 1;
    pinWakeEn[2] = 0;
    pins[2] = 0;
    quietFor(8, hits);
    chk("R8 disabled pin", hits, 0);
    pinWakeEn = '1;
    pins = '1;
    quietFor(8, hits);
    chk("R8 rising edges", hits, 0);
    inHalt = 0;
  endtask

  task automatic tWakeNoVec();
    int hits;
    doReset();
    inHalt = 1;
    pins[0] = 0;
    step(4);
    chk("R10 wake", wakeUp, 1);
    chk("R10 no vector", vecReq, 0);
    inHalt = 0;
    step(1);
    chk("R10 wake pulse ends", wakeUp, 0);
    enableInt();
    quietFor(5, hits);
    chk("R10 request discarded", hits, 0);
    pins = '1;
  endtask

  task automatic tPriority();
    int hits;
    doReset();
    callActive = 1;
    enableInt();
    loadFull(8'hFF);
    startTimer();
    step(4);
    stopTimer();
    inHalt = 1;
    pins[1] = 0;
    step(2);
    pins[4] = 0;
    quietFor(5, hits);
    chk("R11 both held", hits, 0);
    callActive = 0;
    step(1);
    chk("R11 timer first", vecReq, 1);
    chk("R11 timer address", vecAddr, 4'h4);
    chk("R11 no wake with timer", wakeUp, 0);
    step(1);
    chk("R12 gap after vector", vecReq, 0);
    step(1);
    chk("R11 ext second", vecReq, 1);
    chk("R11 ext address", vecAddr, 4'h8);
    chk("R11 ext wake", wakeUp, 1);
    inHalt = 0;
    quietFor(6, hits);
    chk("R11 merged edges give one vector", hits, 0);
    pins = '1;
  endtask

  initial begin
    tReset();
    tLoads();
    tCount();
    tWrap();
    tEnable();
    tTimerVec();
    tExtVec();
    tIgnored();
    tWakeNoVec();
    tPriority();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule